// File: doc/BRIEF.md
# Low-Power Clock Domain Sequencer

This block steers a small system with several clock domains and several clock sources into and out of a doze-style low-power state. Software writes a domain-disable mask, a source-disable mask, a wake-source selection and a low-power control word through one simple write port. Turning things off is gated by acknowledgements at three levels. A domain stops only when every module attached to it has acknowledged the stop request. A source powers down only when no running domain still uses it. The regulator low-power request rises only when all domains have acknowledged.

A wake interrupt clears every disable request. It also loads each domain's clock source from the selection register, but a domain that selects the PLL is parked on the oscillator. Sources come back first. A domain's clock enable returns only after the readiness of its source has been registered for a cycle. Once the PLL reports lock, software writes the selection again to move domains onto it. Outputs report both the requested and the actual on/off state, so software can poll for completion. Oscillators, PLL lock and flash pumps are modelled only as handshake signals.

Top module: `lp_clk_seq`

## Requirements
- R1: A domain whose disable bit (write address 0, bit d for domain d) is set keeps `dom_clk_en[d]` high until every module in its membership mask drives `mod_ack` high. It drops on the second clock edge after the write when the acknowledgements are already present. `dom_stop_req` mirrors the disable mask from the first edge on.
- R2: A source whose disable bit (write address 1, bit s) is set keeps `src_pwr_en[s]` high while any domain with its clock enabled is sourced from it. It drops on the edge after the last such domain stops.
- R3: `vreg_lp_req` is high only when the regulator request bit (write address 3, bit 0) is set and every domain has all of its member acknowledgements. It is registered, one edge after both hold.
- R4: `flash_pump_sleep` is high only when all flash bank sleep bits (write address 3, bits NB..1) are set.
- R5: `doze` is high exactly when the CPU, system and peripheral domains (0, 1, 2) are off, the PLL source (index 1) is off and the oscillator source (index 0) is on.
- R6: The timer domain (3) does not take part in the doze condition, so `doze` can be high while it keeps running.
- R7: A `wake_irq` pulse clears the domain, source, regulator and flash-bank requests. It loads each domain's source from the selection register (address 2, two bits per domain, domain d at bits 2d+1..2d). A selection of the PLL (code 1) is loaded as the oscillator (code 0).
- R8: Outside wake, a write to address 2 moves a domain to its newly selected source only if that source is powered and reports ready in that cycle. For the PLL, ready is the lock indication. Otherwise the domain keeps its current source.
- R9: On wake, sources are re-enabled before their domains. A stopped domain whose request is cleared restarts no earlier than the second edge after its source first reports ready.
- R10: Actual domain and source states (`dom_clk_en`, `src_pwr_en`) are reported separately from the requested states (`dom_stop_req`), and differ while acknowledgements are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 domain disable, 1 source disable, 2 source select, 3 regulator/flash control |
| wr_data | input | 2*ND | Write data |
| mod_ack | input | NM | Per-module clock-stop acknowledge |
| src_rdy | input | NS | Per-source ready (lock for the PLL) |
| wake_irq | input | 1 | Wake interrupt pulse |
| dom_stop_req | output | ND | Requested domain stop |
| dom_clk_en | output | ND | Actual domain clock enable |
| dom_src_sel | output | 2*ND | Active source per domain |
| src_pwr_en | output | NS | Actual source power enable |
| vreg_lp_req | output | 1 | Regulator low-power request |
| flash_pump_sleep | output | 1 | Flash pump sleep |
| doze | output | 1 | Doze state reached |

## Verification
The hardest situation to reach is a wake that follows a full shutdown in which the oscillator itself was powered down. Reaching it needs the dependent domain to stop first, then the oscillator, and then the wake to arrive while the oscillator is not yet ready. The stimulus table walks this path: it disables and acknowledges the domains one group at a time, asks the oscillator to stop while the timer domain still holds it, and then releases that domain. A directed test then raises oscillator readiness and samples once after one edge and again after a second edge, to pin down the restart delay. A selection that names the PLL is written before shutdown, so the wake must park that domain on the oscillator until lock and a fresh write.

// File: rtl/lp_clk_seq.sv
module lp_clk_seq #(
  parameter int ND = 4,
  parameter int NS = 4,
  parameter int NM = 8,
  parameter int NB = 2,
  parameter logic [ND*NM-1:0] DOM_MEMBERS = 32'hC030_0C03,
  parameter logic [ND-1:0] DOZE_DOMS = 4'b0111,
  parameter int OSC_IDX = 0,
  parameter int PLL_IDX = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [2*ND-1:0]   wr_data,
  input  logic [NM-1:0]     mod_ack,
  input  logic [NS-1:0]     src_rdy,
  input  logic              wake_irq,
  output logic [ND-1:0]     dom_stop_req,
  output logic [ND-1:0]     dom_clk_en,
  output logic [2*ND-1:0]   dom_src_sel,
  output logic [NS-1:0]     src_pwr_en,
  output logic              vreg_lp_req,
  output logic              flash_pump_sleep,
  output logic              doze
);
  localparam int SW = 2;
  localparam int DW = SW * ND;
  localparam logic [SW-1:0] OSC = SW'(OSC_IDX);
  localparam logic [SW-1:0] PLL = SW'(PLL_IDX);

  logic [ND-1:0] dom_dis_q, dom_en_q, dom_ack;
  logic [NS-1:0] src_dis_q, src_en_q, rdy_q, src_busy;
  logic [DW-1:0] sel_reg_q, act_sel_q;
  logic [NB-1:0] bank_q;
  logic          vreg_req_q, vreg_lp_q;
  logic          wr;

  assign wr = wr_en & ~wake_irq;

  for (genvar d = 0; d < ND; d++) begin : g_ack
    assign dom_ack[d] = &(mod_ack | ~DOM_MEMBERS[d*NM +: NM]);
  end

  always_comb begin
    src_busy = '0;
    for (int s = 0; s < NS; s++)
      for (int d = 0; d < ND; d++)
        if (dom_en_q[d] && act_sel_q[d*SW +: SW] == SW'(s)) src_busy[s] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dom_dis_q  <= '0;
      src_dis_q  <= '0;
      sel_reg_q  <= '0;
      act_sel_q  <= '0;
      bank_q     <= '0;
      vreg_req_q <= 1'b0;
    end else if (wake_irq) begin
      dom_dis_q  <= '0;
      src_dis_q  <= '0;
      bank_q     <= '0;
      vreg_req_q <= 1'b0;
      for (int d = 0; d < ND; d++)
        act_sel_q[d*SW +: SW] <= (sel_reg_q[d*SW +: SW] == PLL) ? OSC : sel_reg_q[d*SW +: SW];
    end else if (wr) begin
      case (wr_addr)
        2'd0: dom_dis_q <= wr_data[ND-1:0];
        2'd1: src_dis_q <= wr_data[NS-1:0];
        2'd2: begin
          sel_reg_q <= wr_data;
          for (int d = 0; d < ND; d++)
            if (src_rdy[wr_data[d*SW +: SW]] && src_en_q[wr_data[d*SW +: SW]])
              act_sel_q[d*SW +: SW] <= wr_data[d*SW +: SW];
        end
        default: begin
          vreg_req_q <= wr_data[0];
          bank_q     <= wr_data[NB:1];
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dom_en_q  <= '1;
      src_en_q  <= '1;
      rdy_q     <= '0;
      vreg_lp_q <= 1'b0;
    end else begin
      rdy_q     <= src_rdy;
      vreg_lp_q <= vreg_req_q & (&dom_ack);
      for (int d = 0; d < ND; d++) begin
        if (dom_en_q[d] && dom_dis_q[d] && dom_ack[d])
          dom_en_q[d] <= 1'b0;
        else if (!dom_en_q[d] && !dom_dis_q[d] && !wake_irq &&
                 src_en_q[act_sel_q[d*SW +: SW]] && rdy_q[act_sel_q[d*SW +: SW]])
          dom_en_q[d] <= 1'b1;
      end
      for (int s = 0; s < NS; s++) begin
        if (src_dis_q[s] && !src_busy[s]) src_en_q[s] <= 1'b0;
        else if (!src_dis_q[s])           src_en_q[s] <= 1'b1;
      end
    end
  end

  assign dom_stop_req     = dom_dis_q;
  assign dom_clk_en       = dom_en_q;
  assign dom_src_sel      = act_sel_q;
  assign src_pwr_en       = src_en_q;
  assign vreg_lp_req      = vreg_lp_q;
  assign flash_pump_sleep = &bank_q;
  assign doze = ~|(dom_en_q & DOZE_DOMS) & ~src_en_q[PLL_IDX] & src_en_q[OSC_IDX];

  for (genvar d = 0; d < ND; d++) begin : g_dom_chk
    p_dom_stop_acked_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dom_en_q[d]) |-> $past(dom_ack[d] && dom_dis_q[d]));
    p_dom_restart_late_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dom_en_q[d]) |-> $past(rdy_q[act_sel_q[d*SW +: SW]]));
    p_pll_only_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(act_sel_q[d*SW +: SW]) && act_sel_q[d*SW +: SW] == PLL) |-> $past(src_rdy[PLL_IDX] && !wake_irq));
  end

  for (genvar s = 0; s < NS; s++) begin : g_src_chk
    p_src_off_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(src_en_q[s]) |-> $past(!src_busy[s]));
  end

  p_vreg_all_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vreg_lp_req |-> $past(&dom_ack && vreg_req_q));
endmodule

// File: tb/lp_clk_seq_bench.sv
module lp_clk_seq_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0, wake_irq = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0, mod_ack = '0;
  logic [3:0] src_rdy = 4'b1101;
  logic [3:0] dom_stop_req, dom_clk_en, src_pwr_en;
  logic [7:0] dom_src_sel;
  logic       vreg_lp_req, flash_pump_sleep, doze;
  int n_run = 0, n_fail = 0;

  always #5ns clk = ~clk;

  lp_clk_seq u_lp_clk_seq (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .mod_ack, .src_rdy, .wake_irq,
    .dom_stop_req, .dom_clk_en, .dom_src_sel, .src_pwr_en,
    .vreg_lp_req, .flash_pump_sleep, .doze
  );

  typedef struct packed {
    logic       wr;
    logic [1:0] addr;
    logic [7:0] data;
    logic [7:0] ack;
    logic [3:0] rdy;
    logic       wake;
    logic [3:0] e_dom;
    logic [3:0] e_src;
    logic       e_doze;
    logic [3:0] e_stop;
  } vec_t;

  localparam vec_t TBL [9] = '{
    '{1'b1, 2'd2, 8'h01, 8'h00, 4'hD, 1'b0, 4'hF, 4'hF, 1'b0, 4'h0}, // R8 PLL select before lock
    '{1'b1, 2'd0, 8'h07, 8'h00, 4'hD, 1'b0, 4'hF, 4'hF, 1'b0, 4'h7}, // R1 R10 no acks yet
    '{1'b0, 2'd0, 8'h00, 8'h0F, 4'hD, 1'b0, 4'hC, 4'hF, 1'b0, 4'h7}, // R1 doms 0,1 acked
    '{1'b0, 2'd0, 8'h00, 8'h3F, 4'hD, 1'b0, 4'h8, 4'hF, 1'b0, 4'h7}, // R1 dom 2 acked
    '{1'b1, 2'd1, 8'h02, 8'h3F, 4'hD, 1'b0, 4'h8, 4'hD, 1'b1, 4'h7}, // R5 R6 PLL off, doze
    '{1'b1, 2'd1, 8'h03, 8'h3F, 4'hD, 1'b0, 4'h8, 4'hD, 1'b1, 4'h7}, // R2 osc held by timer dom
    '{1'b1, 2'd0, 8'h0F, 8'h3F, 4'hD, 1'b0, 4'h8, 4'hD, 1'b1, 4'hF}, // R1 timer dom awaits ack
    '{1'b0, 2'd0, 8'h00, 8'hFF, 4'hD, 1'b0, 4'h0, 4'hC, 1'b0, 4'hF}, // R2 osc follows dom off
    '{1'b0, 2'd0, 8'h00, 8'hFF, 4'hC, 1'b1, 4'h0, 4'hF, 1'b0, 4'h0}  // R7 R9 wake, osc not ready
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(logic wr, logic [1:0] a, logic [7:0] d, logic wk);
    wr_en = wr; wr_addr = a; wr_data = d; wake_irq = wk;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wake_irq = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #1ms;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset dom", dom_clk_en, 4'hF);
    chk("R10 reset src", src_pwr_en, 4'hF);
    chk("R1 reset stop", dom_stop_req, 4'h0);
    chk("R7 reset sel", dom_src_sel, 8'h00);
    chk("R5 reset doze", doze, 1'b0);
    chk("R3 reset vreg", vreg_lp_req, 1'b0);
    chk("R4 reset pump", flash_pump_sleep, 1'b0);

    for (int i = 0; i < 9; i++) begin
      mod_ack = TBL[i].ack; src_rdy = TBL[i].rdy;
      step(TBL[i].wr, TBL[i].addr, TBL[i].data, TBL[i].wake);
      chk($sformatf("R1/R2 vec%0d dom", i), dom_clk_en, TBL[i].e_dom);
      chk($sformatf("R2/R9 vec%0d src", i), src_pwr_en, TBL[i].e_src);
      chk($sformatf("R5/R6 vec%0d doze", i), doze, TBL[i].e_doze);
      chk($sformatf("R10 vec%0d stop", i), dom_stop_req, TBL[i].e_stop);
    end
    chk("R7 PLL parked on osc", dom_src_sel, 8'h00);

    src_rdy = 4'hD;
    @(posedge clk); @(negedge clk);
    chk("R9 no restart one edge after ready", dom_clk_en, 4'h0);
    @(posedge clk); @(negedge clk);
    chk("R9 restart second edge", dom_clk_en, 4'hF);

    step(1'b1, 2'd2, 8'h01, 1'b0);
    chk("R8 unlocked PLL not taken", dom_src_sel, 8'h00);
    src_rdy = 4'hF;
    step(1'b1, 2'd2, 8'h01, 1'b0);
    chk("R8 locked PLL taken", dom_src_sel, 8'h01);

    step(1'b1, 2'd1, 8'h02, 1'b0);
    chk("R2 PLL held by dom0", src_pwr_en, 4'hF);
    mod_ack = 8'h03;
    step(1'b1, 2'd0, 8'h01, 1'b0);
    chk("R1 dom0 off", dom_clk_en, 4'hE);
    @(posedge clk); @(negedge clk);
    chk("R2 PLL off after dom0", src_pwr_en, 4'hD);

    mod_ack = 8'h3F;
    step(1'b1, 2'd3, 8'h01, 1'b0);
    chk("R3 vreg waits all acks", vreg_lp_req, 1'b0);
    mod_ack = 8'hFF;
    @(posedge clk); @(negedge clk);
    chk("R3 vreg after all acks", vreg_lp_req, 1'b1);

    step(1'b1, 2'd3, 8'h03, 1'b0);
    chk("R4 pump one bank", flash_pump_sleep, 1'b0);
    step(1'b1, 2'd3, 8'h07, 1'b0);
    chk("R4 pump all banks", flash_pump_sleep, 1'b1);

    step(1'b0, 2'd0, 8'h00, 1'b1);
    chk("R7 wake clears vreg", vreg_lp_req, 1'b0);
    chk("R7 wake clears pump", flash_pump_sleep, 1'b0);
    chk("R7 wake clears stop", dom_stop_req, 4'h0);
    chk("R7 wake loads osc for PLL", dom_src_sel, 8'h00);
    chk("R9 dom0 restarts", dom_clk_en, 4'hF);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule